// File: doc/BRIEF.md
# Gated Frequency Counter Controller

This block measures how fast a digital input toggles. It counts the input's rising edges over a sampling window whose length is a fixed number of system clock cycles. It then publishes the count on a result register that only changes when a new measurement ends. A small sequencer runs the measurement without stopping. It clears the edge accumulator, holds the gate open for the chosen number of cycles, and copies the accumulator and its overflow status to the outputs. Then it starts again.

Three window lengths can be chosen. At the default parameters they are one second, one tenth of a second and one hundredth of a second of system clock. A long window resolves low frequencies finely but fills the counter sooner. A short window reaches higher frequencies before the counter limit, at coarser resolution. The input is asynchronous. It passes through a two-flop synchronizer before edge detection.

Top module: `gated_freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, until the first measurement ends, `count_o` is 0, `ovf_o` is 0 and `valid_o` is 0.
- R2: One measurement takes N+2 system clock cycles: one clearing cycle, N gate cycles and one latch cycle. `valid_o` is high for exactly one cycle per measurement, so successive pulses are N+2 cycles apart.
- R3: The published count equals the number of synchronized rising edges of `sig_in` detected during the N gate cycles. For an input with a period of P cycles, where P divides N, the count is N/P.
- R4: `range_sel` is sampled in the clearing cycle. The value 0 selects `GATE_LONG` cycles, 1 selects `GATE_MID`, and 2 or 3 select `GATE_SHORT`.
- R5: `count_o` and `ovf_o` change only in the cycle in which `valid_o` is high, and hold their values between pulses.
- R6: The accumulator saturates at 2^CNT_W-1. `ovf_o` is published as 1 only if an edge arrived while the accumulator already held its maximum. A window with exactly 2^CNT_W-1 edges reports that value with `ovf_o` = 0.
- R7: An input that stays constant through a whole window produces a count of 0 with `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sig_in | input | 1 | Shaped asynchronous signal being measured |
| range_sel | input | 2 | Window length select (0 long, 1 mid, 2/3 short) |
| count_o | output | CNT_W | Latched edge count of the last window |
| ovf_o | output | 1 | Latched overflow status of the last window |
| valid_o | output | 1 | One-cycle pulse when a new result is published |

## Verification
The input is driven as square waves whose period divides the window length. Each window then holds an exact number of edges, whatever its phase, so counts can be predicted without knowing where the window starts. Different periods in the same window show that the count follows the edge rate. The same rate in different windows shows that `range_sel` decodes correctly, including the code that aliases to the short window. Two periods in the long window sit on either side of the counter limit: one reaches exactly full scale with no overflow, the other saturates with the overflow flag set. A constant input gives zero. The spacing between result pulses confirms the window length for each selection.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_GATE  = 2'd1,
        ST_LATCH = 2'd2
    } fm_state_e;

    typedef enum logic [1:0] {
        RNG_LONG  = 2'd0,
        RNG_MID   = 2'd1,
        RNG_SHORT = 2'd2,
        RNG_ALIAS = 2'd3
    } fm_range_e;

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], sig_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[SH_W-2] & ~sh_q[SH_W-1];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer
    import fm_pkg::*;
#(
    parameter int TMR_W      = 28,
    parameter int GATE_LONG  = 250_000_000,
    parameter int GATE_MID   = 25_000_000,
    parameter int GATE_SHORT = 2_500_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [1:0]       range_i,
    output logic             last_o
);
    localparam logic [TMR_W-1:0] LEN_LONG  = TMR_W'(GATE_LONG - 1);
    localparam logic [TMR_W-1:0] LEN_MID   = TMR_W'(GATE_MID - 1);
    localparam logic [TMR_W-1:0] LEN_SHORT = TMR_W'(GATE_SHORT - 1);

    logic [TMR_W-1:0] tmr_d, tmr_q;
    logic [TMR_W-1:0] len_sel;

    always_comb begin
        case (fm_range_e'(range_i))
            RNG_LONG: len_sel = LEN_LONG;
            RNG_MID:  len_sel = LEN_MID;
            default:  len_sel = LEN_SHORT;
        endcase
        tmr_d = tmr_q;
        if (load_i)            tmr_d = len_sel;
        else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign last_o = (tmr_q == '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tmr_q <= LEN_LONG || tmr_q <= LEN_MID || tmr_q <= LEN_SHORT)); // R4
endmodule

// File: rtl/fm_pulse_acc.sv
module fm_pulse_acc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] acc_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic             ovf;
    } acc_s;

    acc_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.acc = '0;
            r_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (r_q.acc == ACC_MAX) r_d.ovf = 1'b1;
            else                    r_d.acc = r_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc_o = r_q.acc;
    assign sat_o = r_q.ovf;

    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (acc_o == ACC_MAX)); // R6
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o == ACC_MAX && !clr_i) |=> (acc_o == ACC_MAX)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(acc_o)); // R3
endmodule

// File: rtl/gated_freq_meter.sv
module gated_freq_meter
    import fm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int GATE_LONG   = 250_000_000,
    parameter int GATE_MID    = 25_000_000,
    parameter int GATE_SHORT  = 2_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [1:0]       range_sel,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             valid_o
);
    localparam int TMR_W = $clog2(GATE_LONG + 1);

    typedef struct packed {
        fm_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             vld;
    } ctl_s;

    ctl_s c_d, c_q;

    logic             rise;
    logic             gate_last;
    logic             gate_open;
    logic             acc_clr;
    logic [CNT_W-1:0] acc_val;
    logic             acc_sat;

    assign gate_open = (c_q.st == ST_GATE);
    assign acc_clr   = (c_q.st == ST_CLEAR);

    fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_in),
        .rise_o (rise)
    );

    fm_gate_timer #(
        .TMR_W      (TMR_W),
        .GATE_LONG  (GATE_LONG),
        .GATE_MID   (GATE_MID),
        .GATE_SHORT (GATE_SHORT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (acc_clr),
        .range_i (range_sel),
        .last_o  (gate_last)
    );

    fm_pulse_acc #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (acc_clr),
        .inc_i (gate_open & rise),
        .acc_o (acc_val),
        .sat_o (acc_sat)
    );

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        unique case (c_q.st)
            ST_CLEAR: c_d.st = ST_GATE;
            ST_GATE:  if (gate_last) c_d.st = ST_LATCH;
            ST_LATCH: begin
                c_d.st  = ST_CLEAR;
                c_d.cnt = acc_val;
                c_d.ovf = acc_sat;
                c_d.vld = 1'b1;
            end
            default:  c_d.st = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st  <= ST_CLEAR;
            c_q.cnt <= '0;
            c_q.ovf <= 1'b0;
            c_q.vld <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o = c_q.cnt;
    assign ovf_o   = c_q.ovf;
    assign valid_o = c_q.vld;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (count_o == $past(count_o) && ovf_o == $past(ovf_o))); // R5
    AST_GATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_val != $past(acc_val) && !$past(acc_clr)) |-> $past(gate_open)); // R3
    AST_LATCH_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(c_q.st) == ST_LATCH)); // R2
endmodule

// File: tb/gated_freq_meter_test.sv
module gated_freq_meter_test;
    localparam int CNT_W = 6;
    localparam int GL    = 252;
    localparam int GM    = 84;
    localparam int GS    = 21;

    typedef struct {
        int    cnt;
        int    ovf;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig_in = 1'b0;
    logic [1:0]       range_sel = 2'd0;
    logic [CNT_W-1:0] count_o;
    logic             ovf_o;
    logic             valid_o;

    int   n_chk = 0;
    int   n_bad = 0;
    int   per = 0;
    int   ph = 0;
    int   cyc = 0;
    bit   done = 0;
    exp_t sb[$];

    gated_freq_meter #(
        .CNT_W(CNT_W), .GATE_LONG(GL), .GATE_MID(GM), .GATE_SHORT(GS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .range_sel(range_sel),
        .count_o(count_o), .ovf_o(ovf_o), .valid_o(valid_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // square wave source, period per cycles, driven away from the active edge
    always @(negedge clk) begin
        if (per == 0) begin
            sig_in <= 1'b0;
        end else begin
            sig_in <= (ph < per / 2);
            ph     <= (ph + 1 >= per) ? 0 : ph + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!valid_o);
    endtask

    // driver: set up a case, let stale windows pass, check spacing, push expectations
    task automatic run_case(input int rsel, input int p, input int n, input int nres,
                            input string req);
        int c0;
        int lim;
        int exp_c;
        int exp_o;
        range_sel = 2'(rsel);
        per = p;
        wait_valid();
        wait_valid();
        c0 = cyc;
        wait_valid();
        check({"R2 gap ", req}, cyc - c0, n + 2);
        lim   = (1 << CNT_W) - 1;
        exp_c = (p == 0) ? 0 : n / p;
        exp_o = (exp_c > lim) ? 1 : 0;
        if (exp_c > lim) exp_c = lim;
        for (int i = 0; i < nres; i++) sb.push_back('{exp_c, exp_o, req});
        while (sb.size() != 0) @(negedge clk);
    endtask

    // monitor: compare each published result against the queue head
    logic [CNT_W-1:0] last_cnt = '0;
    logic             last_ovf = 1'b0;
    bit               moved = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                if (sb.size() != 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.req, " count"}, int'(count_o), e.cnt);
                    check({e.req, " ovf"}, int'(ovf_o), e.ovf);
                    check("R5 hold between pulses", int'(moved), 0);
                end
                moved = 0;
            end else if (count_o != last_cnt || ovf_o != last_ovf) begin
                moved = 1;
            end
            last_cnt = count_o;
            last_ovf = ovf_o;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset count", int'(count_o), 0);
        check("R1 reset ovf", int'(ovf_o), 0);
        check("R1 reset valid", int'(valid_o), 0);
        rst_n = 1'b1;
        repeat (GL) @(negedge clk);
        check("R1 no early valid", int'(valid_o), 0);
        check("R1 count before first result", int'(count_o), 0);

        run_case(0, 4, GL, 2, "R6 exact full scale");
        run_case(0, 2, GL, 2, "R6 saturate");
        run_case(1, 7, GM, 2, "R4 mid window");
        run_case(1, 2, GM, 2, "R3 fast input");
        run_case(1, 84, GM, 2, "R3 single edge");
        run_case(2, 3, GS, 2, "R4 short window");
        run_case(3, 7, GS, 2, "R4 alias code");
        run_case(0, 0, GL, 2, "R7 constant input");
        run_case(0, 28, GL, 2, "R3 slow input");
        finish_run();
    end
endmodule